// File: doc/BRIEF.md
# Flags Register Pop Update Unit

This block owns a 32-bit processor flags register and applies a "pop flags" update to it. Each request supplies a new 32-bit value, an operand size (16 or 32 bits), the current privilege level, a mode input that selects protected or virtual-8086 operation, and a control bit that enables the virtual-8086 extensions. From these inputs and the IOPL field already held in the register, the block builds a per-bit write mask. Privileged flags keep their old values when the requester lacks the right to change them. Outside virtual-8086 mode this never causes a fault.

In virtual-8086 mode a failed permission check does cause a fault. The block then emits a one-cycle general-protection fault pulse and leaves the register untouched. Reserved bit positions are forced to their fixed values on every update. Stack memory access and virtual interrupt flag redirection happen elsewhere. This block performs only the permission check and the masked register write.

Top module: `flag_pop_unit`

## Requirements
- R1: While `rst_n` is low, `flags_q` reads 32'h0000_0002 and `gp_fault` is 0.
- R2: A request is sampled on a rising clock edge when `pop_valid` is 1, and its result appears in `flags_q` after that edge. When `pop_valid` is 0, `flags_q` holds its value and `gp_fault` is 0 after the edge.
- R3: On a permitted request, the status and control bits 0, 2, 4, 6, 7, 8, 10, 11 and 14 always take the popped value.
- R4: When `pop_wide` is 0 (16-bit pop), bits 31:16 keep their old values. AC (bit 18) and ID (bit 21) are loaded only when `pop_wide` is 1.
- R5: IF (bit 9) is loaded only when the effective level is numerically less than or equal to IOPL (bits 13:12). The effective level is `cpl` outside virtual-8086 mode and 3 inside it.
- R6: IOPL (bits 13:12) is loaded only when `v86_mode` is 0 and `cpl` is 0. RF (bit 16) is loaded under the same condition and only when `pop_wide` is 1.
- R7: VM (bit 17), VIF (bit 19) and VIP (bit 20) are never changed by a pop.
- R8: Bit 1 always reads 1. Bits 3, 5, 15 and 31:22 always read 0, whatever value is popped.
- R9: When `v86_mode` is 0, no request raises `gp_fault`. Any privileged bits the requester may not change are left unchanged.
- R10: When `v86_mode` is 1 and `vme_en` is 0, a request is permitted only if IOPL is 3. Otherwise `gp_fault` is 1 for the one cycle after the edge and `flags_q` is not updated.
- R11: When `v86_mode` is 1 and `vme_en` is 1, a 16-bit request is permitted at any IOPL. A 32-bit request is permitted only when IOPL is 3, and otherwise faults as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pop_valid | input | 1 | Pop request strobe |
| pop_data | input | 32 | Value taken from the stack |
| pop_wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| cpl | input | 2 | Current privilege level |
| v86_mode | input | 1 | 1 = virtual-8086 mode, 0 = protected mode |
| vme_en | input | 1 | Virtual-8086 extensions enabled |
| flags_q | output | 32 | Flags register |
| gp_fault | output | 1 | One-cycle general-protection fault pulse |

## Verification
The hardest case to reach is a virtual-8086 request under enabled extensions with IOPL below 3. Here the operand size alone decides between a silent 16-bit update and a fault. IOPL can only be written from level 0 in protected mode, so the stimulus first lowers or raises IOPL through a protected-mode 32-bit pop at level 0. It then switches the mode input and issues 16-bit and 32-bit pops back to back. Randomised requests after the directed part revisit this case under many IOPL values, and a behavioural reference model is compared against the ports on every cycle.

// File: rtl/flag_pop_unit.sv
module flag_pop_unit #(
  parameter int IF_BIT  = 9,
  parameter int RF_BIT  = 16,
  parameter int AC_BIT  = 18,
  parameter int ID_BIT  = 21,
  parameter int PL_LO   = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pop_valid,
  input  logic [31:0] pop_data,
  input  logic        pop_wide,
  input  logic [1:0]  cpl,
  input  logic        v86_mode,
  input  logic        vme_en,
  output logic [31:0] flags_q,
  output logic        gp_fault
);

  localparam logic [31:0] ALWAYS_M = 32'h0000_4DD5;
  localparam logic [31:0] LIVE_M   = 32'h003F_7FD7;
  localparam logic [31:0] ONE_M    = 32'h0000_0002;
  localparam logic [31:0] RESET_V  = ONE_M;
  localparam logic [31:0] IF_M     = 32'h1 << IF_BIT;
  localparam logic [31:0] RF_M     = 32'h1 << RF_BIT;
  localparam logic [31:0] PL_M     = 32'h3 << PL_LO;
  localparam logic [31:0] WIDE_M   = (32'h1 << AC_BIT) | (32'h1 << ID_BIT);

  logic [1:0]  iopl, lvl;
  logic        ring0_prot, v86_ok, deny;
  logic [31:0] wmask, merged;

  assign iopl       = flags_q[PL_LO +: 2];
  assign lvl        = v86_mode ? 2'd3 : cpl;
  assign ring0_prot = !v86_mode && (cpl == 2'd0);
  assign v86_ok     = (iopl == 2'd3) || (vme_en && !pop_wide);
  assign deny       = v86_mode && !v86_ok;

  always_comb begin
    wmask = ALWAYS_M;
    if (lvl <= iopl) wmask |= IF_M;
    if (ring0_prot)  wmask |= PL_M;
    if (ring0_prot && pop_wide) wmask |= RF_M;
    if (pop_wide)    wmask |= WIDE_M;
    else             wmask &= 32'h0000_FFFF;
  end

  assign merged = (((flags_q & ~wmask) | (pop_data & wmask)) & LIVE_M) | ONE_M;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q  <= RESET_V;
      gp_fault <= 1'b0;
    end else begin
      gp_fault <= pop_valid && deny;
      if (pop_valid && !deny) flags_q <= merged;
    end
  end

endmodule

module flag_pop_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pop_valid,
  input logic        pop_wide,
  input logic        v86_mode,
  input logic [31:0] flags_q,
  input logic        gp_fault
);

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[1] && !flags_q[3] && !flags_q[5] && !flags_q[15] && (flags_q[31:22] == 10'd0)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_valid |=> ($stable(flags_q) && !gp_fault)); // R2

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop_wide) |=> (flags_q[31:16] == $past(flags_q[31:16]))); // R4

  AST_VIRT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |=> ($stable(flags_q[17]) && $stable(flags_q[20:19]))); // R7

  AST_PROT_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !v86_mode) |=> !gp_fault); // R9

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && v86_mode) ##1 gp_fault |-> (flags_q == $past(flags_q))); // R10

  AST_FAULT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> $past(pop_valid && v86_mode)); // R10

endmodule

bind flag_pop_unit flag_pop_unit_chk chk_i (.*);

// File: tb/flag_pop_unit_tb.sv
module flag_pop_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pop_valid = 1'b0;
  logic [31:0] pop_data = '0;
  logic        pop_wide = 1'b0;
  logic [1:0]  cpl = '0;
  logic        v86_mode = 1'b0;
  logic        vme_en = 1'b0;
  logic [31:0] flags_q;
  logic        gp_fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] exp_flags = 32'h2;
  logic        exp_fault = 1'b0;

  always #5 clk = ~clk;

  flag_pop_unit dut_i (.*);

  function automatic logic [31:0] ref_pop(input logic [31:0] old, input logic [31:0] d,
      input logic wide, input logic [1:0] c, input logic v8, input logic ve, output logic flt);
    int pl, lvl;
    logic [31:0] r;
    pl  = old[13:12];
    lvl = v8 ? 3 : c;
    flt = 0;
    if (v8 && pl != 3 && !(ve && !wide)) begin
      flt = 1;
      return old;
    end
    r = old;
    for (int b = 0; b < 32; b++) begin
      bit ok;
      if (b > 15 && !wide) ok = 0;
      else case (b)
        0, 2, 4, 6, 7, 8, 10, 11, 14: ok = 1;
        9:       ok = (lvl <= pl);
        12, 13:  ok = (!v8 && c == 0);
        16:      ok = (!v8 && c == 0);
        18, 21:  ok = 1;
        default: ok = 0;
      endcase
      if (ok) r[b] = d[b];
    end
    r[1] = 1'b1;
    return r;
  endfunction

  task automatic check(string tag);
    checks++;
    if (flags_q !== exp_flags || gp_fault !== exp_fault) begin
      fails++;
      $display("FAIL %s: flags=%h fault=%b expected flags=%h fault=%b",
               tag, flags_q, gp_fault, exp_flags, exp_fault);
    end
  endtask

  task automatic step(string tag, logic v, logic [31:0] d, logic w,
                      logic [1:0] c, logic v8, logic ve);
    logic f;
    if (v) begin
      exp_flags = ref_pop(exp_flags, d, w, c, v8, ve, f);
      exp_fault = f;
    end else exp_fault = 1'b0;
    pop_valid = v; pop_data = d; pop_wide = w; cpl = c; v86_mode = v8; vme_en = ve;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");
    step("R6 ring0 wide all ones",     1, 32'hFFFF_FFFF, 1, 0, 0, 0);
    step("R2 idle hold",               0, 32'h0,         1, 0, 0, 0);
    step("R2 idle hold again",         0, 32'h1234_5678, 0, 3, 1, 1);
    step("R4 narrow zero ring0",       1, 32'h0000_0000, 0, 0, 0, 0);
    step("R8 fixed bits all ones",     1, 32'hFFFF_FFFF, 1, 0, 0, 0);
    step("R3 ring3 pattern",           1, 32'h0000_4A95, 1, 3, 0, 0);
    step("R6 ring3 cannot touch IOPL", 1, 32'h0000_0000, 1, 3, 0, 0);
    step("R6 ring0 set IOPL=1",        1, 32'h0000_1200, 1, 0, 0, 0);
    step("R5 ring1 IF allowed",        1, 32'h0000_0000, 1, 1, 0, 0);
    step("R5 ring2 IF denied",         1, 32'h0000_0200, 1, 2, 0, 0);
    step("R9 ring3 no fault",          1, 32'hFFFF_FFFF, 0, 3, 0, 1);
    step("R10 v86 iopl1 faults",       1, 32'h0000_0000, 0, 3, 1, 0);
    step("R11 v86 vme narrow ok",      1, 32'h0000_0001, 0, 3, 1, 1);
    step("R11 v86 vme wide faults",    1, 32'h0000_0000, 1, 3, 1, 1);
    step("R6 ring0 set IOPL=3",        1, 32'h0000_3000, 1, 0, 0, 0);
    step("R10 v86 iopl3 permitted",    1, 32'hFFFF_FFFF, 1, 3, 1, 0);
    step("R7 virtual bits untouched",  1, 32'h0018_0000, 1, 3, 1, 1);
    step("R4 AC ID narrow ignored",    1, 32'h0000_0000, 0, 0, 0, 0);
    step("R6 RF needs wide",           1, 32'h0001_0000, 0, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      step("R3 random", ($urandom % 4) != 0, $urandom, $urandom % 2,
           $urandom % 4, ($urandom % 3) == 0, $urandom % 2);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule